// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block is the digital core of a processor supervisor. An external comparator reports whether the supply is above its threshold. A slow time-base strobe clocks every delay the block measures. The block turns these two inputs into active-low and active-high processor reset outputs and a low-line flag. It also watches a service input that software must toggle. If software stops toggling that input, the block issues a reset pulse and lowers a watchdog status flag.

The block uses two watchdog periods. After every reset it allows a long grace period, so that boot code has time to start servicing the input. Once software shows it is alive by making its first transition after reset ends, a shorter period applies. An input that would be floating or at mid-supply is reported separately as a "disabled" flag, and that flag switches watchdog supervision off. One select input forces the long period at all times. A second select input chooses between a short and a long reset pulse.

Top module: `rst_wd_supervisor`

## Requirements
- R1: While `init_n` is low at a clock edge, the block enters the reset state: `rst_n_o`=0, `rst_o`=1 and `wd_stat_n_o`=1, with the long post-reset watchdog period armed.
- R2: `rst_n_o` returns high only after `supply_ok` has stayed high for a fixed count of clock edges on which `tick`=1. The count is 512 when `variant_long`=0 and 2048 when `variant_long`=1. Edges with `tick`=0 do not count.
- R3: When `supply_ok` is 0, `rst_n_o` is 0 in the same cycle and `low_line_n_o` equals `supply_ok` with no register delay. `wd_stat_n_o` is 1 from the next clock edge on.
- R4: `rst_o` is always the complement of `rst_n_o`.
- R5: The watchdog count restarts when reset ends, whatever caused the reset. Without any counted input transition, a timeout occurs at the 4096th tick after release, and `rst_n_o` and `wd_stat_n_o` both go low at that edge.
- R6: A transition on `wd_in` in either direction is acted on 3 clock edges after it is applied, through a two-stage synchroniser, and restarts the count. After the first such transition following reset release, the timeout is 1024 ticks, provided `period_long`=0.
- R7: If `wd_in` never toggles, reset pulses repeat: each one follows 4096 ticks after the previous release.
- R8: With `period_long`=1, the timeout is 4096 ticks even after a `wd_in` transition.
- R9: `wd_stat_n_o` goes low on a timeout and stays low through the resulting reset. It returns high only on a `wd_in` transition that is counted after release. Transitions while reset is asserted are ignored.
- R10: While `wd_off`=1, no timeout occurs and `wd_stat_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| init_n | input | 1 | Synchronous active-low initialisation |
| tick | input | 1 | Time-base strobe; each high cycle counts as one tick |
| supply_ok | input | 1 | Supply above threshold, from an external comparator |
| wd_in | input | 1 | Watchdog service input (asynchronous) |
| wd_off | input | 1 | Watchdog disabled (input floating or at mid-supply) |
| period_long | input | 1 | 1 = always use the long watchdog period |
| variant_long | input | 1 | 1 = 2048-tick reset pulse, 0 = 512-tick |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| low_line_n_o | output | 1 | Low when the supply is below threshold |
| wd_stat_n_o | output | 1 | Active-low watchdog timeout status |

## Verification
The assertions assume several things about the inputs. `supply_ok`, `tick` and the select inputs must be synchronous to `clk`. Only `wd_in` may change at any time. The select inputs must not change in the same cycle as a timeout. The stimulus drives every input on the falling clock edge. It holds `tick` high except in one deliberate gap. It changes `period_long`, `variant_long` and `wd_off` only well away from a counted terminal tick, so each expected edge falls on a single, unambiguous cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Default delays, counted in time-base ticks
    localparam int unsigned SUP_RST_SHORT = 512;
    localparam int unsigned SUP_RST_LONG  = 2048;
    localparam int unsigned SUP_WD_SHORT  = 1024;
    localparam int unsigned SUP_WD_LONG   = 4096;

    // Watchdog mode controls, grouped as one bundle
    typedef struct packed {
        logic off;       // supervision disabled
        logic long_per;  // force the long period
    } wd_mode_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic init_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!init_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int unsigned RST_SHORT = 512,
    parameter int unsigned RST_LONG  = 2048
) (
    input  logic clk,
    input  logic init_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic wd_timeout,
    input  logic variant_long,
    output logic in_rst_o
);
    localparam int unsigned RCW = $clog2(RST_LONG);
    localparam logic [RCW-1:0] LAST_S = RCW'(RST_SHORT - 1);
    localparam logic [RCW-1:0] LAST_L = RCW'(RST_LONG - 1);

    typedef struct packed {
        logic           act;
        logic [RCW-1:0] cnt;
    } rst_st_t;

    rst_st_t        st_d, st_q;
    logic [RCW-1:0] last;

    always_comb begin
        st_d = st_q;
        last = variant_long ? LAST_L : LAST_S;
        if (!supply_ok || wd_timeout) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act && tick) begin
            if (st_q.cnt == last) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!init_n) st_q <= '{act: 1'b1, cnt: '0};
        else         st_q <= st_d;
    end

    assign in_rst_o = st_q.act;

    // Release only on a counted terminal tick
    assert_release_count_R2: assert property (@(posedge clk) disable iff (!init_n)
        $fell(st_q.act) |-> ($past(tick) && ($past(st_q.cnt) == $past(last))));

    // Low supply always leaves the block in reset
    assert_lowsup_hold_R3: assert property (@(posedge clk) disable iff (!init_n)
        !supply_ok |=> st_q.act);
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
    import sup_pkg::*;
#(
    parameter int unsigned WD_SHORT = 1024,
    parameter int unsigned WD_LONG  = 4096
) (
    input  logic     clk,
    input  logic     init_n,
    input  logic     tick,
    input  logic     supply_ok,
    input  logic     in_rst,
    input  logic     wd_s,
    input  wd_mode_t mode,
    output logic     timeout_o,
    output logic     stat_n_o
);
    localparam int unsigned WCW = $clog2(WD_LONG);
    localparam logic [WCW-1:0] LAST_S = WCW'(WD_SHORT - 1);
    localparam logic [WCW-1:0] LAST_L = WCW'(WD_LONG - 1);

    typedef struct packed {
        logic           short_en;
        logic           stat_n;
        logic           prev;
        logic [WCW-1:0] cnt;
    } wd_st_t;

    wd_st_t         st_d, st_q;
    logic           edge_seen;
    logic           fire;
    logic [WCW-1:0] last;

    always_comb begin
        st_d      = st_q;
        st_d.prev = wd_s;
        edge_seen = wd_s ^ st_q.prev;
        last      = (st_q.short_en && !mode.long_per) ? LAST_S : LAST_L;
        fire      = supply_ok && !mode.off && !in_rst && !edge_seen &&
                    tick && (st_q.cnt == last);
        if (!supply_ok) begin
            st_d.cnt      = '0;
            st_d.short_en = 1'b0;
            st_d.stat_n   = 1'b1;
        end else if (mode.off) begin
            st_d.cnt      = '0;
            st_d.stat_n   = 1'b1;
            st_d.short_en = in_rst ? 1'b0 : st_q.short_en;
        end else if (in_rst) begin
            st_d.cnt      = '0;
            st_d.short_en = 1'b0;
        end else if (edge_seen) begin
            st_d.cnt      = '0;
            st_d.short_en = 1'b1;
            st_d.stat_n   = 1'b1;
        end else if (tick) begin
            if (fire) begin
                st_d.cnt    = '0;
                st_d.stat_n = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!init_n) st_q <= '{short_en: 1'b0, stat_n: 1'b1, prev: 1'b0, cnt: '0};
        else         st_q <= st_d;
    end

    assign timeout_o = fire;
    assign stat_n_o  = st_q.stat_n;

    assert_timeout_flag_R9: assert property (@(posedge clk) disable iff (!init_n)
        fire |=> !st_q.stat_n);

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!init_n)
        mode.off |=> st_q.stat_n);

    assert_short_cause_R6: assert property (@(posedge clk) disable iff (!init_n)
        $rose(st_q.short_en) |-> $past(edge_seen));

    assert_rst_rearm_R5: assert property (@(posedge clk) disable iff (!init_n)
        in_rst |=> !st_q.short_en);
endmodule

// File: rtl/rst_wd_supervisor.sv
module rst_wd_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned RST_SHORT   = SUP_RST_SHORT,
    parameter int unsigned RST_LONG    = SUP_RST_LONG,
    parameter int unsigned WD_SHORT    = SUP_WD_SHORT,
    parameter int unsigned WD_LONG     = SUP_WD_LONG,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic init_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic wd_in,
    input  logic wd_off,
    input  logic period_long,
    input  logic variant_long,
    output logic rst_n_o,
    output logic rst_o,
    output logic low_line_n_o,
    output logic wd_stat_n_o
);
    logic     wd_s;
    logic     in_rst;
    logic     wd_timeout;
    logic     rst_active;
    wd_mode_t mode;

    sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .init_n (init_n),
        .din    (wd_in),
        .dout   (wd_s)
    );

    sup_rst_timer #(.RST_SHORT(RST_SHORT), .RST_LONG(RST_LONG)) u_rst (
        .clk          (clk),
        .init_n       (init_n),
        .tick         (tick),
        .supply_ok    (supply_ok),
        .wd_timeout   (wd_timeout),
        .variant_long (variant_long),
        .in_rst_o     (in_rst)
    );

    always_comb begin
        mode.off      = wd_off;
        mode.long_per = period_long;
        rst_active    = in_rst | ~supply_ok;
    end

    sup_wd_timer #(.WD_SHORT(WD_SHORT), .WD_LONG(WD_LONG)) u_wd (
        .clk       (clk),
        .init_n    (init_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .in_rst    (rst_active),
        .wd_s      (wd_s),
        .mode      (mode),
        .timeout_o (wd_timeout),
        .stat_n_o  (wd_stat_n_o)
    );

    assign rst_n_o      = ~rst_active;
    assign rst_o        = rst_active;
    assign low_line_n_o = supply_ok;
endmodule

// File: tb/rst_wd_supervisor_test.sv
`timescale 1ns/1ps
module rst_wd_supervisor_test;
    logic clk = 1'b0;
    logic init_n, tick, supply_ok, wd_in, wd_off, period_long, variant_long;
    logic rst_n_o, rst_o, low_line_n_o, wd_stat_n_o;

    int unsigned cyc = 0;
    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        bit          rn;
        bit          sn;
        bit          ll;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_wd_supervisor uut (
        .clk(clk), .init_n(init_n), .tick(tick), .supply_ok(supply_ok),
        .wd_in(wd_in), .wd_off(wd_off), .period_long(period_long),
        .variant_long(variant_long), .rst_n_o(rst_n_o), .rst_o(rst_o),
        .low_line_n_o(low_line_n_o), .wd_stat_n_o(wd_stat_n_o)
    );

    // Driver side: schedule an expectation, kept sorted by cycle
    task automatic expect_at(int unsigned at, bit rn, bit sn, bit ll, string tag);
        exp_t e;
        int   idx;
        e.at = at; e.rn = rn; e.sn = sn; e.ll = ll; e.tag = tag;
        idx = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > at) begin
                idx = i;
                break;
            end
        end
        sb.insert(idx, e);
    endtask

    task automatic wait_cyc(int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard: %0d expectations never reached, first tag %s",
                     sb.size(), sb[0].tag);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor side: compare due items away from the active edge
    always @(negedge clk) begin
        while (sb.size() != 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: check at cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (rst_n_o !== e.rn || wd_stat_n_o !== e.sn || low_line_n_o !== e.ll) begin
                n_fail++;
                $display("FAIL %s @%0d: rst_n/stat_n/low_line = %b%b%b, expected %b%b%b",
                         e.tag, cyc, rst_n_o, wd_stat_n_o, low_line_n_o, e.rn, e.sn, e.ll);
            end
            n_chk++;
            if (rst_o !== ~e.rn) begin
                n_fail++;
                $display("FAIL R4 @%0d: rst_o = %b, expected %b", cyc, rst_o, ~e.rn);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, actual running expected done", cyc);
            finish_run();
        end
    end

    initial begin
        int unsigned c0, rel, t, t3, x, x2, t4, t6, s1, s2, r7, t8, x3, t9, s3;
        init_n = 1'b0; tick = 1'b1; supply_ok = 1'b1; wd_in = 1'b0;
        wd_off = 1'b0; period_long = 1'b0; variant_long = 1'b0;
        repeat (3) @(negedge clk);
        expect_at(cyc + 1, 1'b0, 1'b1, 1'b1, "R1 init state");
        @(negedge clk);
        @(negedge clk);
        c0 = cyc;
        init_n = 1'b1;
        expect_at(c0 + 511, 1'b0, 1'b1, 1'b1, "R2 reset held 511");
        expect_at(c0 + 512, 1'b1, 1'b1, 1'b1, "R2 release at 512");
        rel = c0 + 512;
        // R5 and R7: no service, long timeout and repeated pulses
        expect_at(rel + 4095, 1'b1, 1'b1, 1'b1, "R5 before long timeout");
        expect_at(rel + 4096, 1'b0, 1'b0, 1'b1, "R5 long timeout");
        t = rel + 4096;
        expect_at(t + 511, 1'b0, 1'b0, 1'b1, "R9 stat low in reset");
        expect_at(t + 512, 1'b1, 1'b0, 1'b1, "R9 stat low after release");
        expect_at(t + 512 + 4096, 1'b0, 1'b0, 1'b1, "R7 repeated pulse");
        t3 = t + 512 + 4096 + 512;
        wait_cyc(t3 + 10);
        // R6: first edge arms the short period; a later edge restarts it
        x = cyc;
        wd_in = 1'b1;
        x2 = x + 500;
        expect_at(x + 2, 1'b1, 1'b0, 1'b1, "R6 sync latency");
        expect_at(x + 3, 1'b1, 1'b1, 1'b1, "R9 edge clears stat");
        expect_at(x + 1027, 1'b1, 1'b1, 1'b1, "R6 restart by second edge");
        expect_at(x2 + 1026, 1'b1, 1'b1, 1'b1, "R6 before short timeout");
        expect_at(x2 + 1027, 1'b0, 1'b0, 1'b1, "R6 short timeout");
        wait_cyc(x2);
        wd_in = 1'b0;
        t4 = x2 + 1027 + 512;
        wait_cyc(t4 - 200);
        wd_in = 1'b1;   // edge during reset: must be ignored
        expect_at(t4 + 1, 1'b1, 1'b0, 1'b1, "R9 edge in reset ignored");
        expect_at(t4 + 4095, 1'b1, 1'b0, 1'b1, "R5 long period rearmed");
        expect_at(t4 + 4096, 1'b0, 1'b0, 1'b1, "R5 long timeout after reset");
        t6 = t4 + 4096 + 512;
        wait_cyc(t6 + 20);
        // R3: supply loss; R2: tick gating on recovery
        s1 = cyc;
        supply_ok = 1'b0;
        expect_at(s1 + 1, 1'b0, 1'b1, 1'b0, "R3 supply low");
        wait_cyc(s1 + 50);
        s2 = cyc;
        supply_ok = 1'b1;
        tick = 1'b0;
        expect_at(s2 + 1, 1'b0, 1'b1, 1'b1, "R3 low line follows");
        expect_at(s2 + 611, 1'b0, 1'b1, 1'b1, "R2 no tick no count");
        expect_at(s2 + 612, 1'b1, 1'b1, 1'b1, "R2 release after gated ticks");
        r7 = s2 + 612;
        expect_at(r7 + 4095, 1'b1, 1'b1, 1'b1, "R5 restart after supply reset");
        expect_at(r7 + 4096, 1'b0, 1'b0, 1'b1, "R5 timeout after supply reset");
        wait_cyc(s2 + 100);
        tick = 1'b1;
        t8 = r7 + 4096 + 512;
        wait_cyc(t8 + 5);
        // R8: long period forced
        period_long = 1'b1;
        wait_cyc(t8 + 10);
        x3 = cyc;
        wd_in = 1'b0;
        expect_at(x3 + 3, 1'b1, 1'b1, 1'b1, "R8 edge counted");
        expect_at(x3 + 1027, 1'b1, 1'b1, 1'b1, "R8 no short timeout");
        expect_at(x3 + 4098, 1'b1, 1'b1, 1'b1, "R8 before long timeout");
        expect_at(x3 + 4099, 1'b0, 1'b0, 1'b1, "R8 long timeout");
        t9 = x3 + 4099 + 512;
        wait_cyc(t9);
        period_long = 1'b0;
        wait_cyc(t9 + 5);
        // R2: long-reset variant
        variant_long = 1'b1;
        wait_cyc(t9 + 10);
        supply_ok = 1'b0;
        wait_cyc(t9 + 15);
        s3 = cyc;
        supply_ok = 1'b1;
        expect_at(s3 + 2047, 1'b0, 1'b1, 1'b1, "R2 long variant held");
        expect_at(s3 + 2048, 1'b1, 1'b1, 1'b1, "R2 long variant release");
        wait_cyc(s3 + 2050);
        // R10: disabled watchdog never times out
        wd_off = 1'b1;
        wait_cyc(s3 + 2150);
        wd_in = 1'b1;
        expect_at(s3 + 2048 + 6000, 1'b1, 1'b1, 1'b1, "R10 disabled no timeout");
        wait_cyc(s3 + 2048 + 6010);
        done = 1'b1;
        finish_run();
    end
endmodule